// File: doc/BRIEF.md
# Flash Program/Erase Suspend-Resume Sequencer

This block runs word-program and block-erase operations for a block-erasable flash array. The cell timing is replaced by modeled countdown timers. Already-decoded commands arrive as an operation code with a target block index. The block reports a ready flag, one suspended flag for the program and one for the erase, and three sticky error bits: program failure, erase failure and sequence violation.

An erase in progress can be suspended. While it is suspended, reads and word programs to other blocks may proceed. A program, including one started inside an erase suspend, can also be suspended, but only for reads to blocks other than its own. Suspensions nest: resumes unwind them in last-in, first-out order. A suspend takes effect a fixed number of cycles after it is requested, and the time the operation still needs is kept for the resume. If a request breaks a suspend rule, it is rejected and raises the sequence error bit.

A failure seen when an operation finishes sets an error bit that stays set. While a failure bit is set, no new program or erase starts. A clear-status command removes all error bits.

Top module: `flash_susp_seq`

## Requirements
- R1: After reset, ready is 1, both suspended flags are 0, all three error bits are 0 and rd_grant is 0.
- R2: cmd_op codes are: 1 program, 2 erase, 3 suspend, 4 resume, 5 clear status, 6 read; 0 and 7 do nothing. When the block is idle, an accepted program holds ready low for exactly PROG_CYC cycles, and an accepted erase holds it low for exactly ERASE_CYC cycles.
- R3: A suspend issued while an operation runs sets that operation's suspended flag and raises ready exactly SUSP_LAT cycles after the command cycle. If the operation finishes on or before that cycle, no flag is set.
- R4: A resume restarts the kept remaining time. Across any number of suspends, the total number of cycles with ready low for an operation equals its nominal duration.
- R5: While an erase is suspended, a read of another block is granted (rd_grant high for the one cycle after the command), and a program to another block starts.
- R6: While an erase is suspended, a read or program aimed at the erased block sets err_seq, gives no grant and starts nothing.
- R7: While a program is suspended, reads to other blocks are granted. A program command, or a read of the block being programmed, sets err_seq and starts nothing.
- R8: When a program is suspended inside an erase suspend, the first resume continues the program and leaves the erase suspended. A second resume, after the program completes, continues the erase.
- R9: An erase command while any operation is suspended sets err_seq and starts nothing.
- R10: If op_fail is high in the cycle an operation completes, err_prog or err_erase is set and stays set. While either is set, program and erase commands are refused with no effect. Clear status zeroes all three error bits.
- R11: While ready is low, read, program, erase and resume commands are ignored: they give no grant and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Operation code (see R2) |
| cmd_blk | input | $clog2(BLOCKS) | Target block index |
| op_fail | input | 1 | Modeled cell failure, sampled at completion |
| ready | output | 1 | No operation is currently running |
| prog_susp | output | 1 | A program is suspended |
| erase_susp | output | 1 | An erase is suspended |
| err_prog | output | 1 | Sticky program failure |
| err_erase | output | 1 | Sticky erase failure |
| err_seq | output | 1 | Sticky sequence violation |
| rd_grant | output | 1 | Read accepted, one-cycle pulse |

## Verification
The case that needs care is a suspend whose latency ends on the same edge where the operation's timer expires. The design resolves it in favour of completion, so no suspended flag appears. The bench forces this overlap by issuing the suspend exactly SUSP_LAT cycles before the expected end, and also one cycle earlier. Random suspend offsets that sweep across the whole operation then cover the region around that boundary. In each case the bench compares the suspended flag and the total busy time with values its own functions compute.

// File: rtl/flash_susp_seq.sv
module flash_susp_seq #(
  parameter int BLOCKS    = 16,
  parameter int PROG_CYC  = 12,
  parameter int ERASE_CYC = 60,
  parameter int SUSP_LAT  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  input  logic [2:0]                cmd_op,
  input  logic [$clog2(BLOCKS)-1:0] cmd_blk,
  input  logic                      op_fail,
  output logic                      ready,
  output logic                      prog_susp,
  output logic                      erase_susp,
  output logic                      err_prog,
  output logic                      err_erase,
  output logic                      err_seq,
  output logic                      rd_grant
);
  localparam int BW = $clog2(BLOCKS);
  localparam int PW = $clog2(PROG_CYC + 1);
  localparam int EW = $clog2(ERASE_CYC + 1);
  localparam int SW = $clog2(SUSP_LAT + 1);
  localparam logic [2:0] OP_PROG = 3'd1, OP_ERASE = 3'd2, OP_SUSP = 3'd3,
                         OP_RES = 3'd4, OP_CLR = 3'd5, OP_READ = 3'd6;

  logic          p_act, e_act;
  logic [BW-1:0] p_blk, e_blk;
  logic [PW-1:0] p_rem;
  logic [EW-1:0] e_rem;
  logic [SW-1:0] sp_cnt;

  logic p_run, e_run, busy, p_done, e_done, hold, idle_cmd;
  logic c_prog, c_erase, c_susp, c_res, c_clr, c_read;
  logic prog_ok, prog_bad, erase_ok, erase_bad, read_ok, read_bad;
  logic susp_go, sp_fire, res_p, res_e;

  assign p_run  = p_act & ~prog_susp;
  assign e_run  = e_act & ~erase_susp;
  assign busy   = p_run | e_run;
  assign p_done = p_run && (p_rem == PW'(1));
  assign e_done = e_run && (e_rem == EW'(1));
  assign hold   = err_prog | err_erase;
  assign ready  = ~busy;

  assign c_prog  = cmd_valid && cmd_op == OP_PROG;
  assign c_erase = cmd_valid && cmd_op == OP_ERASE;
  assign c_susp  = cmd_valid && cmd_op == OP_SUSP;
  assign c_res   = cmd_valid && cmd_op == OP_RES;
  assign c_clr   = cmd_valid && cmd_op == OP_CLR;
  assign c_read  = cmd_valid && cmd_op == OP_READ;
  assign idle_cmd = ~busy;

  assign prog_bad  = idle_cmd & c_prog & (p_act | (e_act & (cmd_blk == e_blk)));
  assign prog_ok   = idle_cmd & c_prog & ~hold & ~prog_bad;
  assign erase_bad = idle_cmd & c_erase & (p_act | e_act);
  assign erase_ok  = idle_cmd & c_erase & ~hold & ~erase_bad;
  assign read_bad  = idle_cmd & c_read & ((e_act & (cmd_blk == e_blk)) |
                                          (p_act & (cmd_blk == p_blk)));
  assign read_ok   = idle_cmd & c_read & ~read_bad;
  assign susp_go   = c_susp & busy & (sp_cnt == '0);
  assign sp_fire   = (sp_cnt == SW'(1));
  assign res_p     = idle_cmd & c_res & prog_susp;
  assign res_e     = idle_cmd & c_res & erase_susp & ~p_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_act <= 1'b0; prog_susp <= 1'b0; p_blk <= '0; p_rem <= '0;
    end else if (p_done) begin
      p_act <= 1'b0;
    end else if (prog_ok) begin
      p_act <= 1'b1; p_blk <= cmd_blk; p_rem <= PW'(PROG_CYC);
    end else begin
      if (p_run) p_rem <= p_rem - PW'(1);
      if (sp_fire && p_run) prog_susp <= 1'b1;
      else if (res_p)       prog_susp <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_act <= 1'b0; erase_susp <= 1'b0; e_blk <= '0; e_rem <= '0;
    end else if (e_done) begin
      e_act <= 1'b0;
    end else if (erase_ok) begin
      e_act <= 1'b1; e_blk <= cmd_blk; e_rem <= EW'(ERASE_CYC);
    end else begin
      if (e_run) e_rem <= e_rem - EW'(1);
      if (sp_fire && e_run) erase_susp <= 1'b1;
      else if (res_e)       erase_susp <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                sp_cnt <= '0;
    else if (p_done || e_done) sp_cnt <= '0;
    else if (susp_go)          sp_cnt <= SW'(SUSP_LAT);
    else if (sp_cnt != '0)     sp_cnt <= sp_cnt - SW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_prog <= 1'b0; err_erase <= 1'b0; err_seq <= 1'b0; rd_grant <= 1'b0;
    end else begin
      err_prog  <= (err_prog  & ~c_clr) | (p_done & op_fail);
      err_erase <= (err_erase & ~c_clr) | (e_done & op_fail);
      err_seq   <= (err_seq   & ~c_clr) | prog_bad | erase_bad | read_bad;
      rd_grant  <= read_ok;
    end
  end

  // R5
  nest_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p_act && e_act) |-> erase_susp);

  // R4
  prog_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_susp |=> (p_rem == $past(p_rem)));

  // R4
  erase_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_susp |=> (e_rem == $past(e_rem)));

  // R8
  lifo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_susp && p_act) |=> erase_susp);

  // R10
  refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && c_prog && !p_act) |=> !p_act);

  // R3
  pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_cnt != '0) |-> busy);
endmodule

// File: tb/flash_susp_seq_tb.sv
`timescale 1ns/1ps
module flash_susp_seq_tb_top;
  localparam int PC = 12, EC = 60, SL = 3;
  localparam logic [2:0] PROG = 3'd1, ERASE = 3'd2, SUSP = 3'd3,
                         RES = 3'd4, CLR = 3'd5, READ = 3'd6;

  logic clk = 1'b0, rst_n, cmd_valid, op_fail;
  logic [2:0] cmd_op;
  logic [3:0] cmd_blk;
  logic ready, prog_susp, erase_susp, err_prog, err_erase, err_seq, rd_grant;
  int checks = 0, errors = 0, busy_tot = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  flash_susp_seq #(.BLOCKS(16), .PROG_CYC(PC), .ERASE_CYC(EC), .SUSP_LAT(SL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
    .op_fail(op_fail), .ready(ready), .prog_susp(prog_susp), .erase_susp(erase_susp),
    .err_prog(err_prog), .err_erase(err_erase), .err_seq(err_seq), .rd_grant(rd_grant));

  always @(negedge clk) if (rst_n === 1'b1 && ready === 1'b0) busy_tot <= busy_tot + 1;

  function automatic int op_cycles(input logic [2:0] op);
    return (op == PROG) ? PC : EC;
  endfunction

  function automatic bit susp_expected(input int s, input int cyc);
    return (s + SL) < cyc;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input int blk);
    cmd_valid = 1'b1; cmd_op = op; cmd_blk = blk[3:0];
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  task automatic run_susp(input logic [2:0] op, input int blk, input int w, input int other);
    int t0, s, cyc;
    bit ex;
    cyc = op_cycles(op);
    t0 = busy_tot;
    issue(op, blk);
    repeat (w) @(negedge clk);
    issue(SUSP, 0);
    s = 1 + w;
    ex = susp_expected(s, cyc);
    repeat (SL - 1) @(negedge clk);
    chk("R3 flag before latency", (op == PROG) ? prog_susp : erase_susp, 0);
    @(negedge clk);
    chk("R3 flag after latency", (op == PROG) ? prog_susp : erase_susp, ex);
    if (ex) begin
      chk("R3 ready while suspended", ready, 1);
      issue(READ, other);
      chk((op == PROG) ? "R7 read other block" : "R5 read other block", rd_grant, 1);
      repeat ($urandom_range(0, 5)) @(negedge clk);
      issue(RES, 0);
    end
    wait_ready();
    @(negedge clk);
    chk("R4 total busy cycles", busy_tot - t0, cyc);
    chk("R4 flags clear", prog_susp | erase_susp, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int t0;
    void'($urandom(32'd2718));
    cmd_valid = 0; cmd_op = 0; cmd_blk = 0; op_fail = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready", ready, 1);
    chk("R1 susp flags", prog_susp | erase_susp, 0);
    chk("R1 errors", err_prog | err_erase | err_seq, 0);
    chk("R1 grant", rd_grant, 0);

    t0 = busy_tot; issue(PROG, 3); wait_ready(); @(negedge clk);
    chk("R2 program duration", busy_tot - t0, PC);
    t0 = busy_tot; issue(ERASE, 9); wait_ready(); @(negedge clk);
    chk("R2 erase duration", busy_tot - t0, EC);

    issue(PROG, 4);
    issue(READ, 7);
    chk("R11 read while busy grant", rd_grant, 0);
    issue(RES, 0);
    chk("R11 no error while busy", err_seq, 0);
    wait_ready();

    t0 = busy_tot;
    issue(ERASE, 2); repeat (5) @(negedge clk);
    issue(SUSP, 0); repeat (SL) @(negedge clk);
    chk("R3 erase suspended", erase_susp, 1);
    issue(READ, 2);
    chk("R6 read erased block err", err_seq, 1);
    chk("R6 read erased block grant", rd_grant, 0);
    issue(CLR, 0);
    chk("R10 clear seq", err_seq, 0);
    issue(READ, 5);
    chk("R5 read other", rd_grant, 1);
    issue(PROG, 2);
    chk("R6 program erased block err", err_seq, 1);
    chk("R6 program erased block no start", ready, 1);
    issue(CLR, 0);
    issue(PROG, 5);
    chk("R5 program other starts", ready, 0);
    repeat (2) @(negedge clk);
    issue(SUSP, 0); repeat (SL) @(negedge clk);
    chk("R8 nested program suspended", prog_susp, 1);
    issue(READ, 5);
    chk("R7 read programmed block err", err_seq, 1);
    issue(CLR, 0);
    issue(PROG, 6);
    chk("R7 program in program suspend err", err_seq, 1);
    chk("R7 program in program suspend no start", ready, 1);
    issue(CLR, 0);
    issue(READ, 3);
    chk("R7 read other in nest", rd_grant, 1);
    issue(ERASE, 1);
    chk("R9 erase while suspended err", err_seq, 1);
    issue(CLR, 0);
    issue(RES, 0);
    chk("R8 first resume program", prog_susp, 0);
    chk("R8 first resume keeps erase", erase_susp, 1);
    wait_ready();
    chk("R8 erase still suspended", erase_susp, 1);
    issue(RES, 0);
    chk("R8 second resume erase", erase_susp, 0);
    wait_ready(); @(negedge clk);
    chk("R4 nested busy total", busy_tot - t0, EC + PC);

    run_susp(PROG, 0, PC - SL - 2, 4);
    run_susp(PROG, 0, PC - SL - 1, 4);
    run_susp(ERASE, 8, EC - SL - 1, 1);

    op_fail = 1; issue(PROG, 1); wait_ready(); op_fail = 0;
    chk("R10 program fail", err_prog, 1);
    issue(PROG, 2);
    chk("R10 program refused", ready, 1);
    issue(ERASE, 2);
    chk("R10 erase refused", ready, 1);
    chk("R10 refusal no seq err", err_seq, 0);
    issue(CLR, 0);
    chk("R10 cleared", err_prog, 0);
    op_fail = 1; issue(ERASE, 4); wait_ready(); op_fail = 0;
    chk("R10 erase fail", err_erase, 1);
    issue(CLR, 0);
    chk("R10 erase cleared", err_erase, 0);

    for (int i = 0; i < 24; i++) begin
      logic [2:0] op;
      int blk, oth, w;
      op = $urandom_range(0, 1) ? ERASE : PROG;
      blk = $urandom_range(0, 15);
      oth = (blk + 1 + $urandom_range(0, 14)) % 16;
      w = $urandom_range(0, op_cycles(op) + 1);
      run_susp(op, blk, w, oth);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule